// File: doc/BRIEF.md
# Round-Key Expansion Engine with Per-Row Substitution

This block turns a 256-bit cipher key into the full schedule of round keys for a 14-round cipher whose state has eight 32-bit columns. It builds 120 words of 32 bits, which form 15 round keys of 256 bits each. One word is produced per clock after a start pulse. The words sit in an internal register file that the round datapath reads one 256-bit round key at a time through a round-index port.

Word substitution does not use a single S-box. Byte lane j of a word, with lane 0 the most significant byte, passes through the S-box assigned to state row j. The four S-boxes are computed in logic from finite-field inverses and affine maps, so no tables are stored. A done flag tells the datapath that the whole schedule is valid.

Top module: `key_expand_engine`

## Requirements
- R1: After reset, busy_o and done_o are low and rd_key_o is zero for every value of rd_round_i.
- R2: A start pulse taken while idle captures key_i; round key 0 then equals key_i, word 0 being key_i[255:224] and word 7 key_i[31:0].
- R3: For i from 8 to 119, word w[i] equals w[i-8] XOR t, where t is SubWord(RotWord(w[i-1])) XOR the round constant when i mod 8 = 0, SubWord(w[i-1]) when i mod 8 = 4, and w[i-1] otherwise. RotWord maps bytes [a0,a1,a2,a3] to [a1,a2,a3,a0], a0 being bits 31:24.
- R4: SubWord sends byte lane j (lane 0 = bits 31:24) through S-box j. With inv_p(x) the inverse of x modulo polynomial p (inv of 0 taken as 0) and aff(b,c) = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ c: S0(x) = aff(inv_11B(x), 63); S1(x) = aff(inv_11B(x) ^ A5, 63); S2(x) = aff(inv_11B(x), 63) ^ 02; S3(x) = aff(inv_1F5(x), D3).
- R5: The round constant used at word i = 8k is the byte 02^(k-1) modulo polynomial 11B, placed in bits 31:24 with the other three bytes zero, giving 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36, 6C, D8, AB, 4D for k = 1 to 14.
- R6: After an accepted start, busy_o is high for exactly 112 cycles; done_o rises in the cycle busy_o falls, is never high together with busy_o, and stays high until the next accepted start.
- R7: A start pulse while busy_o is high is ignored: the schedule in progress completes from the first key and no second expansion follows.
- R8: rd_round_i = r (0 to 14) drives rd_key_o with words 8r to 8r+7, word 8r in bits 255:224; rd_round_i = 15 gives zero.
- R9: A start taken after done_o clears done_o and builds the schedule for the new key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| key_i | input | 256 | Cipher key, byte 0 in bits 255:248 |
| busy_o | output | 1 | Expansion in progress |
| done_o | output | 1 | Whole schedule valid |
| rd_round_i | input | 4 | Round index for reading |
| rd_key_o | output | 256 | Round key selected by rd_round_i |

## Verification
The assertions watch the control flow on every cycle: busy and done never overlap, done only rises as busy falls, an accepted start loads the index at word 8, a start during a run leaves the index stepping normally, the round constant never becomes zero, and an out-of-range read index yields zero. The values of the words themselves, meaning the four substitution boxes, the rotation and constant placement, and the read packing, can only be shown by the bench scenarios, which compare every round key against a schedule computed independently from an all-zero key, an all-ones key and two mixed keys, and which also measure the busy length and inject a start mid-run.

// File: rtl/key_exp_pkg.sv
package key_exp_pkg;
  localparam int NK      = 8;
  localparam int NB      = 8;
  localparam int NR      = 14;
  localparam int WORD_W  = 32;
  localparam int NROW    = 4;
  localparam int KEY_W   = NK * WORD_W;
  localparam int RKEY_W  = NB * WORD_W;
  localparam int NWORDS  = NB * (NR + 1);
  localparam int IDX_W   = $clog2(NWORDS);
  localparam int RND_W   = $clog2(NR + 2);
  localparam int NK_W    = $clog2(NK);

  localparam logic [7:0] POLY_STD = 8'h1B;
  localparam logic [7:0] POLY_ALT = 8'hF5;
  localparam logic [7:0] C_STD    = 8'h63;
  localparam logic [7:0] C_ALT    = 8'hD3;
  localparam logic [7:0] PRE_ROW1 = 8'hA5;
  localparam logic [7:0] POST_ROW2 = 8'h02;

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {TMP_PASS, TMP_SUB, TMP_ROT_SUB} tmp_mode_e;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] poly);
    logic [7:0] acc, aa;
    acc = '0;
    aa  = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) acc = acc ^ aa;
      aa = aa[7] ? ((aa << 1) ^ poly) : (aa << 1);
    end
    return acc;
  endfunction

  // x^254 by square-and-multiply; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] x, input logic [7:0] poly);
    logic [7:0] acc, sq;
    acc = 8'h01;
    sq  = x;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq, poly);
      acc = gf_mul(acc, sq, poly);
    end
    return acc;
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] b, input logic [7:0] c);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ c[i];
    return r;
  endfunction
endpackage

// File: rtl/key_sbox_row.sv
module key_sbox_row
  import key_exp_pkg::*;
#(
  parameter int ROW = 0
) (
  input  logic [7:0] in_i,
  output logic [7:0] out_o
);
  generate
    if (ROW == 0) begin : g_row0
      assign out_o = affine(gf_inv(in_i, POLY_STD), C_STD);
    end else if (ROW == 1) begin : g_row1
      assign out_o = affine(gf_inv(in_i, POLY_STD) ^ PRE_ROW1, C_STD);
    end else if (ROW == 2) begin : g_row2
      assign out_o = affine(gf_inv(in_i, POLY_STD), C_STD) ^ POST_ROW2;
    end else begin : g_row3
      assign out_o = affine(gf_inv(in_i, POLY_ALT), C_ALT);
    end
  endgenerate
endmodule

// File: rtl/key_sub_word.sv
module key_sub_word
  import key_exp_pkg::*;
(
  input  word_t      word_i,
  input  tmp_mode_e  mode_i,
  input  logic [7:0] rcon_i,
  output word_t      word_o
);
  word_t rot_w, sub_in, sub_out;

  assign rot_w  = {word_i[WORD_W-9:0], word_i[WORD_W-1 -: 8]};
  assign sub_in = (mode_i == TMP_ROT_SUB) ? rot_w : word_i;

  // lane j (j=0 at MSB) uses the S-box of row j
  for (genvar j = 0; j < NROW; j++) begin : g_lane
    key_sbox_row #(.ROW(j)) u_sbox (
      .in_i (sub_in [WORD_W-1-8*j -: 8]),
      .out_o(sub_out[WORD_W-1-8*j -: 8])
    );
  end

  always_comb begin
    unique case (mode_i)
      TMP_ROT_SUB: word_o = sub_out ^ {rcon_i, {(WORD_W-8){1'b0}}};
      TMP_SUB:     word_o = sub_out;
      default:     word_o = word_i;
    endcase
  end
endmodule

// File: rtl/key_word_store.sv
module key_word_store
  import key_exp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  word_t             wr_data_i,
  input  logic [RND_W-1:0]  rd_round_i,
  output logic [RKEY_W-1:0] rd_key_o
);
  word_t mem_q [NWORDS];
  logic  rd_valid;

  assign rd_valid = (int'(rd_round_i) <= NR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NWORDS; k++) mem_q[k] <= '0;
    end else if (load_i) begin
      for (int k = 0; k < NK; k++) mem_q[k] <= key_i[KEY_W-1-WORD_W*k -: WORD_W];
    end else if (wr_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  for (genvar k = 0; k < NB; k++) begin : g_rd
    logic [IDX_W-1:0] addr;
    assign addr = rd_valid ? IDX_W'(int'(rd_round_i) * NB + k) : '0;
    assign rd_key_o[RKEY_W-1-WORD_W*k -: WORD_W] = rd_valid ? mem_q[addr] : '0;
  end

  a_r8_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_round_i) > NR) |-> (rd_key_o == '0));
endmodule

// File: rtl/key_expand_engine.sv
module key_expand_engine
  import key_exp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              busy_o,
  output logic              done_o,
  input  logic [RND_W-1:0]  rd_round_i,
  output logic [RKEY_W-1:0] rd_key_o
);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(NK);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NWORDS - 1);

  logic             busy_q, done_q, accept;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       rcon_q;
  word_t            win_q [NK];
  word_t            tmp_w, new_w;
  tmp_mode_e        mode;

  assign accept = start_i && !busy_q;

  always_comb begin
    if (idx_q[NK_W-1:0] == '0)                 mode = TMP_ROT_SUB;
    else if (idx_q[NK_W-1:0] == NK_W'(NK / 2)) mode = TMP_SUB;
    else                                       mode = TMP_PASS;
  end

  key_sub_word u_sub (
    .word_i(win_q[NK-1]),
    .mode_i(mode),
    .rcon_i(rcon_q),
    .word_o(tmp_w)
  );

  assign new_w = win_q[0] ^ tmp_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      rcon_q <= 8'h01;
      for (int k = 0; k < NK; k++) win_q[k] <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      idx_q  <= FIRST_IDX;
      rcon_q <= 8'h01;
      for (int k = 0; k < NK; k++) win_q[k] <= key_i[KEY_W-1-WORD_W*k -: WORD_W];
    end else if (busy_q) begin
      for (int k = 0; k < NK-1; k++) win_q[k] <= win_q[k+1];
      win_q[NK-1] <= new_w;
      idx_q <= idx_q + 1'b1;
      if (mode == TMP_ROT_SUB) rcon_q <= gf_mul(rcon_q, 8'h02, POLY_STD);
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  key_word_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .key_i     (key_i),
    .wr_i      (busy_q),
    .wr_idx_i  (idx_q),
    .wr_data_i (new_w),
    .rd_round_i(rd_round_i),
    .rd_key_o  (rd_key_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r6_busy_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  a_r6_done_on_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));
  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && idx_q == FIRST_IDX));
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o && idx_q != LAST_IDX) |=> (busy_o && idx_q == $past(idx_q) + 1'b1));
  a_r5_rcon_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (rcon_q != 8'h00));
  a_r6_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (idx_q >= FIRST_IDX && idx_q <= LAST_IDX));
endmodule

// File: tb/key_expand_engine_bench.sv
`timescale 1ns/100ps
module key_expand_engine_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [255:0] key = '0;
  logic         busy, done;
  logic [3:0]   rd_round = '0;
  logic [255:0] rd_key;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_q [$];

  always #10 clk = ~clk;

  key_expand_engine u_key_expand_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
    .busy_o(busy), .done_o(done), .rd_round_i(rd_round), .rd_key_o(rd_key));

  function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b, logic [8:0] p);
    logic [15:0] prod = '0;
    for (int k = 0; k < 8; k++) if (b[k]) prod ^= 16'(a) << k;
    for (int k = 15; k >= 8; k--) if (prod[k]) prod ^= 16'(p) << (k - 8);
    return prod[7:0];
  endfunction

  function automatic logic [7:0] m_inv(logic [7:0] x, logic [8:0] p);
    for (int y = 1; y < 256; y++) if (m_mul(x, 8'(y), p) == 8'h01) return 8'(y);
    return 8'h00;
  endfunction

  function automatic logic [7:0] rl(logic [7:0] b, int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] m_aff(logic [7:0] b, logic [7:0] c);
    return b ^ rl(b,1) ^ rl(b,2) ^ rl(b,3) ^ rl(b,4) ^ c;
  endfunction

  function automatic logic [7:0] m_sbox(int row, logic [7:0] x);
    case (row)
      0: return m_aff(m_inv(x, 9'h11B), 8'h63);
      1: return m_aff(m_inv(x, 9'h11B) ^ 8'hA5, 8'h63);
      2: return m_aff(m_inv(x, 9'h11B), 8'h63) ^ 8'h02;
      default: return m_aff(m_inv(x, 9'h1F5), 8'hD3);
    endcase
  endfunction

  function automatic logic [31:0] m_sub(logic [31:0] w);
    logic [31:0] r;
    for (int j = 0; j < 4; j++) r[31-8*j -: 8] = m_sbox(j, w[31-8*j -: 8]);
    return r;
  endfunction

  task automatic push_expected(logic [255:0] k);
    logic [31:0] w [120];
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 8; i++) w[i] = k[255-32*i -: 32];
    for (int i = 8; i < 120; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 8 == 0) begin
        t = m_sub({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = m_mul(rc, 8'h02, 9'h11B);
      end else if (i % 8 == 4) t = m_sub(t);
      w[i] = w[i-8] ^ t;
    end
    for (int i = 0; i < 120; i++) exp_q.push_back(w[i]);
  endtask

  task automatic check(bit ok, string tag, logic [255:0] act, logic [255:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // monitor: on each rise of done, read all round keys and compare against queue
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk);
      if (done && !prev) begin
        for (int r = 0; r < 15; r++) begin
          logic [255:0] e = '0;
          rd_round = 4'(r);
          #0.5;
          for (int k = 0; k < 8; k++)
            e[255-32*k -: 32] = (exp_q.size() > 0) ? exp_q.pop_front() : 32'hx;
          check(rd_key === e, (r == 0) ? "R2 R8 round0" : "R3 R4 R5 R8 round", rd_key, e);
        end
      end
      prev = done;
    end
  end

  task automatic run_key(logic [255:0] k, bit inject, logic [255:0] other);
    int cnt = 0;
    push_expected(k);
    @(negedge clk); start = 1; key = k;
    @(negedge clk); start = 0;
    while (!done && cnt < 1000) begin
      if (busy) cnt++;
      start = inject && (cnt == 5);
      if (start) key = other;
      @(negedge clk);
    end
    start = 0;
    check(cnt == 112, "R6 busy length", 256'(cnt), 256'd112);
    check(done && !busy, "R6 done after run", {busy, done}, 256'b01);
    repeat (4) @(negedge clk);
    check(done && !busy, "R6 done holds", {busy, done}, 256'b01);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] k1, k2, k3;
    k1 = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
    k2 = 256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4;
    k3 = '1;
    repeat (3) @(negedge clk);
    check(!busy && !done, "R1 flags", {busy, done}, 256'b0);
    for (int r = 0; r < 16; r++) begin
      rd_round = 4'(r);
      #0.5;
      check(rd_key == '0, "R1 reset contents", rd_key, '0);
    end
    rst_n = 1;
    run_key(k1, 0, '0);
    run_key(k2, 1, k3);
    check(exp_q.size() == 0, "R7 no extra expansion", 256'(exp_q.size()), '0);
    run_key(k3, 0, '0);
    rd_round = 4'd0; #0.5;
    check(rd_key == k3, "R9 restart new key", rd_key, k3);
    run_key('0, 0, '0);
    rd_round = 4'd15; #0.5;
    check(rd_key == '0, "R8 index 15 zero", rd_key, '0);
    check(exp_q.size() == 0, "R7 queue drained", 256'(exp_q.size()), '0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule